// File: doc/BRIEF.md
# Byte-Lane Bus Parity Monitor

This block sits on the system side of a 64-bit processor bus. It watches data beats and inquire addresses and reports parity faults a fixed two clocks after the strobe that makes them valid. The data bus is split into eight byte lanes. Each lane carries one parity bit. A lane is judged only on a beat the ready strobe validates, and only if that lane's byte enable is active. The address check covers the upper address bits together with one address parity bit. It is judged when the external inquire strobe validates the address.

The monitor is a pure observer. It samples its inputs on every rising edge, so it can never push back: there is no ready output and no back-pressure. Every qualified beat or strobe yields exactly one result, two edges later. When strobes arrive on consecutive cycles, their results leave on consecutive cycles in the same order. Besides the summary data error flag, a per-lane error vector shows which lanes failed. Error handling and logging belong to the consumer of these flags.

Top module: `bus_parity_monitor`

## Requirements
- R1: While reset is asserted, and until the first strobe has crossed the two-stage pipeline, `data_err`, `data_err_lanes` and `addr_err` are all 0.
- R2: Lane n (n = 0..7) covers `bus_data[8n+7:8n]`, and `lane_par[n]` is its parity bit. Parity is even. The lane fails when the XOR of its eight data bits and its parity bit is 1.
- R3: A lane whose `lane_en[n]` is 0 (enables are active high) never sets `data_err_lanes[n]`, whatever its data and parity.
- R4: A beat with `beat_rdy` low never produces a data error, whatever the lane contents.
- R5: Suppose a qualified beat is presented in clock cycle T. Its lane result appears on `data_err_lanes` in cycle T+2, for exactly one cycle. Nothing appears in cycle T+1.
- R6: `data_err` is 1 in exactly those cycles where at least one bit of `data_err_lanes` is 1.
- R7: The address check is even parity over `snoop_addr[31:5]` plus `addr_par`. Bits 4:0 of the address have no effect.
- R8: When `snoop_stb` is high in cycle T with an address parity failure, `addr_err` is 1 in cycle T+2 only. Without the strobe, `addr_err` stays 0.
- R9: Strobes in consecutive cycles give independent results in consecutive cycles, in their original order.
- R10: A data beat and an address strobe in the same cycle are checked independently. Both flags may rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_rdy | input | 1 | Ready strobe; validates the data beat in this cycle |
| lane_en | input | 8 | Byte enables, active high, one per lane |
| bus_data | input | 64 | Data bus, lane n on bits 8n+7:8n |
| lane_par | input | 8 | Parity bit per lane |
| snoop_stb | input | 1 | External strobe validating the inquire address |
| snoop_addr | input | 32 | Inquire address |
| addr_par | input | 1 | Address parity bit |
| data_err | output | 1 | Data parity error pulse, two clocks after the beat |
| data_err_lanes | output | 8 | Failing lanes, aligned with `data_err` |
| addr_err | output | 1 | Address parity error pulse, two clocks after the strobe |

## Verification
A data beat with `beat_rdy` and an inquire address with `snoop_stb` can arrive in the same cycle. Both travel the same two-stage pipeline. The bench raises both strobes in one cycle with both checks failing, and requires both flags in exactly the same later cycle. It then repeats this with only one side failing, to show that neither flag leaks into the other. Back-to-back beats with different failing lanes complete the picture: each beat's lane vector must come out in its own cycle, in order.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
package bpm_pkg;
  // Widest vector the shared parity helper handles.
  localparam int unsigned PAR_VEC_W = 64;

  // Return 1 when the masked bits have odd weight (even parity violated).
  function automatic logic odd_weight(input logic [PAR_VEC_W-1:0] bits,
                                      input logic [PAR_VEC_W-1:0] mask);
    return ^(bits & mask);
  endfunction
endpackage

// File: rtl/bpm_lane_cell.sv
`timescale 1ns/1ps
// One byte lane: even parity over data bits plus the lane parity bit,
// qualified by the beat strobe and the lane enable.
module bpm_lane_cell #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              qual,
  input  logic              en,
  input  logic [LANE_W-1:0] lane_bits,
  input  logic              par_bit,
  output logic              bad
);
  import bpm_pkg::*;
  localparam int unsigned VW = LANE_W + 1;

  logic [PAR_VEC_W-1:0] vec;
  logic [PAR_VEC_W-1:0] msk;

  always_comb begin
    vec = '0;
    msk = '0;
    vec[VW-1:0] = {lane_bits, par_bit};
    msk[VW-1:0] = '1;
    bad = qual & en & odd_weight(vec, msk);
  end
endmodule

// File: rtl/bpm_addr_cell.sv
`timescale 1ns/1ps
// Address check: even parity over the upper address field plus parity bit.
module bpm_addr_cell #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ADDR_LO = 5
) (
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              par_bit,
  output logic              bad
);
  import bpm_pkg::*;
  localparam int unsigned FIELD_W = ADDR_W - ADDR_LO;
  localparam int unsigned VW      = FIELD_W + 1;

  logic [PAR_VEC_W-1:0] vec;
  logic [PAR_VEC_W-1:0] msk;

  always_comb begin
    vec = '0;
    msk = '0;
    vec[VW-1:0] = {addr[ADDR_W-1:ADDR_LO], par_bit};
    msk[VW-1:0] = '1;
    bad = stb & odd_weight(vec, msk);
  end
endmodule

// File: rtl/bpm_delay_line.sv
`timescale 1ns/1ps
// Fixed-latency register chain; q follows d after DEPTH rising edges.
module bpm_delay_line #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/bus_parity_monitor.sv
`timescale 1ns/1ps
module bus_parity_monitor #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ADDR_LO = 5,
  parameter int unsigned LATENCY = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat_rdy,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES*LANE_W-1:0]   bus_data,
  input  logic [LANES-1:0]          lane_par,
  input  logic                      snoop_stb,
  input  logic [ADDR_W-1:0]         snoop_addr,
  input  logic                      addr_par,
  output logic                      data_err,
  output logic [LANES-1:0]          data_err_lanes,
  output logic                      addr_err
);
  // Pipe payload: {address fail, any lane fail, lane vector}
  localparam int unsigned PIPE_W = LANES + 2;

  logic [LANES-1:0]  lane_bad;
  logic              any_bad;
  logic              addr_bad;
  logic [PIPE_W-1:0] pipe_in;
  logic [PIPE_W-1:0] pipe_out;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    bpm_lane_cell #(.LANE_W(LANE_W)) u_cell (
      .qual      (beat_rdy),
      .en        (lane_en[n]),
      .lane_bits (bus_data[n*LANE_W +: LANE_W]),
      .par_bit   (lane_par[n]),
      .bad       (lane_bad[n])
    );
  end

  bpm_addr_cell #(.ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO)) u_addr (
    .stb     (snoop_stb),
    .addr    (snoop_addr),
    .par_bit (addr_par),
    .bad     (addr_bad)
  );

  assign any_bad = |lane_bad;
  assign pipe_in = {addr_bad, any_bad, lane_bad};

  bpm_delay_line #(.W(PIPE_W), .DEPTH(LATENCY)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pipe_in),
    .q     (pipe_out)
  );

  assign data_err_lanes = pipe_out[LANES-1:0];
  assign data_err       = pipe_out[LANES];
  assign addr_err       = pipe_out[LANES+1];
endmodule

// File: rtl/bpm_checker.sv
`timescale 1ns/1ps
module bpm_checker #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ADDR_LO = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    beat_rdy,
  input logic [LANES-1:0]        lane_en,
  input logic [LANES*LANE_W-1:0] bus_data,
  input logic [LANES-1:0]        lane_par,
  input logic                    snoop_stb,
  input logic [ADDR_W-1:0]       snoop_addr,
  input logic                    addr_par,
  input logic                    data_err,
  input logic [LANES-1:0]        data_err_lanes,
  input logic                    addr_err
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  wire warm = (since_rst == 2'd2);

  // R1
  always @(negedge clk)
    if (!rst_n) reset_quiet_chk: assert (!data_err && !addr_err && data_err_lanes == '0);

  // R3
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> ((data_err_lanes & ~$past(lane_en, 2)) == '0));

  // R4
  no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(beat_rdy, 2)) |-> (data_err_lanes == '0));

  // R5
  data_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |-> (warm && $past(beat_rdy, 2)));

  // R6
  summary_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_err == (|data_err_lanes));

  // R8
  addr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (addr_err == $past(snoop_stb && (^{snoop_addr[ADDR_W-1:ADDR_LO], addr_par}), 2)));
endmodule

bind bus_parity_monitor bpm_checker #(
  .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_rdy(beat_rdy), .lane_en(lane_en),
  .bus_data(bus_data), .lane_par(lane_par), .snoop_stb(snoop_stb),
  .snoop_addr(snoop_addr), .addr_par(addr_par), .data_err(data_err),
  .data_err_lanes(data_err_lanes), .addr_err(addr_err)
);

// File: tb/sim_bus_parity_monitor.sv
`timescale 1ns/1ps
module sim_bus_parity_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_rdy = 1'b0;
  logic [7:0]  lane_en = '0;
  logic [63:0] bus_data = '0;
  logic [7:0]  lane_par = '0;
  logic        snoop_stb = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        addr_par = 1'b0;
  logic        data_err;
  logic [7:0]  data_err_lanes;
  logic        addr_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_parity_monitor u0 (
    .clk(clk), .rst_n(rst_n), .beat_rdy(beat_rdy), .lane_en(lane_en),
    .bus_data(bus_data), .lane_par(lane_par), .snoop_stb(snoop_stb),
    .snoop_addr(snoop_addr), .addr_par(addr_par), .data_err(data_err),
    .data_err_lanes(data_err_lanes), .addr_err(addr_err)
  );

  // Even-parity bit for each lane of a data word.
  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int n = 0; n < 8; n++) p[n] = ^d[8*n +: 8];
    return p;
  endfunction

  function automatic logic good_apar(input logic [31:0] a);
    return ^a[31:5];
  endfunction

  function automatic logic [7:0] exp_lanes(input logic r, input logic [7:0] e,
                                           input logic [63:0] d, input logic [7:0] p);
    return r ? (e & (good_par(d) ^ p)) : 8'h00;
  endfunction

  function automatic logic exp_aerr(input logic s, input logic [31:0] a, input logic ap);
    return s & (good_apar(a) ^ ap);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input logic [7:0] el, input logic ea, input string req);
    chk(data_err_lanes == el, req, "lanes", data_err_lanes, el);
    chk(data_err == (|el), req, "data_err (R6)", data_err, |el);
    chk(addr_err == ea, req, "addr_err", addr_err, ea);
  endtask

  task automatic drive(input logic r, input logic [7:0] e, input logic [63:0] d,
                       input logic [7:0] p, input logic s, input logic [31:0] a,
                       input logic ap);
    beat_rdy = r; lane_en = e; bus_data = d; lane_par = p;
    snoop_stb = s; snoop_addr = a; addr_par = ap;
  endtask

  task automatic idle();
    drive(1'b0, 8'h00, 64'h0, 8'h00, 1'b0, 32'h0, 1'b0);
  endtask

  // One stimulus cycle; result must show only in the second cycle after it (R5, R8).
  task automatic one_beat(input logic r, input logic [7:0] e, input logic [63:0] d,
                          input logic [7:0] p, input logic s, input logic [31:0] a,
                          input logic ap, input string req);
    logic [7:0] el;
    logic ea;
    el = exp_lanes(r, e, d, p);
    ea = exp_aerr(s, a, ap);
    @(negedge clk); drive(r, e, d, p, s, a, ap);
    @(negedge clk); idle(); check_out(8'h00, 1'b0, {req, " early R5"});
    @(negedge clk); check_out(el, ea, req);
    @(negedge clk); check_out(8'h00, 1'b0, {req, " pulse R5"});
  endtask

  localparam logic [63:0] D0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [31:0] A0 = 32'hDEAD_BEE0;

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    drive(1'b1, 8'hFF, D0, ~good_par(D0), 1'b1, A0, ~good_apar(A0));
    @(negedge clk);
    check_out(8'h00, 1'b0, "R1 in reset");
    idle();
    rst_n = 1'b1;
    @(negedge clk); check_out(8'h00, 1'b0, "R1 after release");
    @(negedge clk); check_out(8'h00, 1'b0, "R1 after release");
  endtask

  task automatic t_lane_parity();
    one_beat(1, 8'hFF, D0, good_par(D0), 0, 0, 0, "R2 clean");
    one_beat(1, 8'hFF, D0, good_par(D0) ^ 8'h08, 0, 0, 0, "R2 lane3 par");
    one_beat(1, 8'hFF, D0 ^ 64'h8000_0000_0000_0001, good_par(D0), 0, 0, 0, "R2 lanes 0,7 data");
    one_beat(1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 0, 0, 0, "R2 all ones");
  endtask

  task automatic t_mask();
    one_beat(1, 8'h7F, D0, good_par(D0) ^ 8'h81, 0, 0, 0, "R3 lane7 masked");
    one_beat(1, 8'h00, D0, ~good_par(D0), 0, 0, 0, "R3 all masked");
  endtask

  task automatic t_no_ready();
    one_beat(0, 8'hFF, D0, ~good_par(D0), 0, 0, 0, "R4 no ready");
  endtask

  task automatic t_addr();
    one_beat(0, 0, 0, 0, 1, A0, good_apar(A0), "R7 addr good");
    one_beat(0, 0, 0, 0, 1, A0, ~good_apar(A0), "R8 addr bad");
    one_beat(0, 0, 0, 0, 1, A0 ^ 32'h0000_001F, good_apar(A0), "R7 low bits ignored");
    one_beat(0, 0, 0, 0, 1, A0 ^ 32'h8000_0000, good_apar(A0), "R7 bit31 covered");
    one_beat(0, 0, 0, 0, 0, A0, ~good_apar(A0), "R8 no strobe");
  endtask

  task automatic t_back_to_back();
    @(negedge clk); drive(1, 8'hFF, D0, good_par(D0) ^ 8'h02, 1, A0, ~good_apar(A0));
    @(negedge clk); drive(1, 8'hFF, D0, good_par(D0) ^ 8'h40, 1, A0, good_apar(A0));
    @(negedge clk); idle(); check_out(8'h02, 1'b1, "R9 first");
    @(negedge clk); check_out(8'h40, 1'b0, "R9 second");
    @(negedge clk); check_out(8'h00, 1'b0, "R9 drained");
  endtask

  task automatic t_same_cycle();
    one_beat(1, 8'hFF, D0, good_par(D0) ^ 8'h10, 1, A0, ~good_apar(A0), "R10 both");
    one_beat(1, 8'hFF, D0, good_par(D0), 1, A0, ~good_apar(A0), "R10 addr only");
    one_beat(1, 8'hFF, D0, good_par(D0) ^ 8'h20, 1, A0, good_apar(A0), "R10 data only");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset();
    t_lane_parity();
    t_mask();
    t_no_ready();
    t_addr();
    t_back_to_back();
    t_same_cycle();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule